// File: doc/BRIEF.md
# Branch Trace Sync Request Controller

This block sits beside a program-trace message generator and decides, branch by branch, whether the next direct or indirect branch message must carry full synchronisation information (the long form) or may use the compact form. It watches a set of events that leave a trace decoder unable to follow the program flow: a reset or a fresh enable of tracing, a return from a low-power state or from debug mode, a trace queue overrun, an edge on an external event pin, and two ways of losing a branch message. It also watches two saturating counters. Each of these events sets a sticky request, and the next emitted branch message consumes it.

The block has no message payload, queue or output serialiser. For every retired branch it reports whether a message is emitted, whether that message carries sync, and a two-bit message kind that selects the message code downstream. All outputs are registered, so they appear one clock after the branch strobe.

Top module: `trace_sync_ctrl`

## Requirements
- R1: Out of reset, the first branch message carries sync. The first branch message after `trace_en` goes from 0 to 1 also carries sync.
- R2: A pulse on `lp_exit` or `dbg_exit` makes the next branch message carry sync.
- R3: A `q_overrun` pulse sampled while `trace_en` is high makes the next branch message carry sync.
- R4: A second counter counts branch messages sent without sync. It saturates at 255 and returns to zero on every sync message. After 255 consecutive compact messages, the next message carries sync.
- R5: An instruction counter counts `seq_instr` strobes, saturates at 255, and returns to zero on every branch strobe, even one that coincides with a `seq_instr` strobe. A branch seen while the count is 255 carries sync. A branch seen at a count of 254 does not.
- R6: A rising edge of `evt_in` requests sync only while `evt_cfg` equals 2'b01. An edge seen with any other `evt_cfg` value is ignored.
- R7: A pulse on `lost_secure` or on `lost_collide` makes the next branch message carry sync.
- R8: Pending requests are sticky and clear when a sync message is emitted. A cause that arrives in the same cycle as that message stays pending and applies to the following message. With nothing pending and neither counter at its limit, a message is compact.
- R9: While `trace_en` is low, branch strobes produce no message (`msg_valid` stays 0).
- R10: A branch strobe in cycle t with `trace_en` high gives `msg_valid`=1 in cycle t+1. `msg_type` is {sync, indirect}, so 00 means direct compact, 01 indirect compact, 10 direct with sync and 11 indirect with sync. `br_indirect` wins when both strobes are high. When no message is emitted, all message outputs are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| trace_en | input | 1 | Program trace enable level |
| br_direct | input | 1 | Direct branch retired strobe |
| br_indirect | input | 1 | Indirect branch retired strobe |
| seq_instr | input | 1 | Sequential instruction retired strobe |
| lp_exit | input | 1 | Return from low-power state pulse |
| dbg_exit | input | 1 | Return from debug mode pulse |
| q_overrun | input | 1 | Trace queue overrun pulse |
| evt_in | input | 1 | External event pin level |
| evt_cfg | input | 2 | Event pin control; 2'b01 enables sync requests |
| lost_secure | input | 1 | Branch message dropped on secure access |
| lost_collide | input | 1 | Branch message dropped on queue-entry collision |
| msg_valid | output | 1 | A branch message is emitted |
| msg_sync | output | 1 | The emitted message carries sync |
| msg_type | output | 2 | Message kind {sync, indirect} |

## Verification
Every message output is due exactly one clock after the branch strobe that caused it. A cause pulse can only affect a branch sampled at a later edge. The bench drives inputs just after a falling edge and advances a reference model through the same step. At the next falling edge it compares all three outputs against the model's predictions, so each comparison falls one register stage after the stimulus it belongs to. Directed sequences place causes one cycle before a branch, in the same cycle as a branch, and at counts of 254 and 255 before the randomised phase starts.

// File: rtl/trace_sync_pkg.sv
package trace_sync_pkg;

    // Latched cause positions inside the sticky pending vector
    localparam int CAUSE_ENABLE  = 0;
    localparam int CAUSE_LPEXIT  = 1;
    localparam int CAUSE_DBGEXIT = 2;
    localparam int CAUSE_OVERRUN = 3;
    localparam int CAUSE_EVENT   = 4;
    localparam int CAUSE_SECURE  = 5;
    localparam int CAUSE_COLLIDE = 6;
    localparam int N_LATCHED     = 7;

    // Counter-derived causes appended above the latched ones
    localparam int N_CAUSES      = N_LATCHED + 2;

    localparam logic [1:0] EVT_CFG_SYNC = 2'b01;

    typedef enum logic [1:0] {
        KIND_DIRECT      = 2'b00,
        KIND_INDIRECT    = 2'b01,
        KIND_DIRECT_SYNC = 2'b10,
        KIND_INDIR_SYNC  = 2'b11
    } msg_kind_t;

    typedef struct packed {
        logic      valid;
        logic      sync;
        msg_kind_t kind;
    } msg_out_t;

    typedef struct packed {
        logic en_prev;
        logic evt_prev;
    } edge_state_t;

endpackage

// File: rtl/sync_sat_counter.sv
module sync_sat_counter #(
    parameter int W   = 8,
    parameter int MAX = 255
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr,
    input  logic         inc,
    output logic [W-1:0] cnt,
    output logic         at_max
);
    localparam logic [W-1:0] MAX_V = W'(MAX);

    logic [W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (clr) begin
            cnt_d = '0;
        end else if (inc && (cnt_q != MAX_V)) begin
            cnt_d = cnt_q + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end

    assign cnt    = cnt_q;
    assign at_max = (cnt_q == MAX_V);

    // Saturation for both the period counter (R4) and the instruction counter (R5)
    assert_sat_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (at_max && inc && !clr) |=> at_max);

    assert_clear_zero_R5: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (cnt == '0));

endmodule

// File: rtl/sync_cause_detect.sv
module sync_cause_detect
    import trace_sync_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 trace_en,
    input  logic                 lp_exit,
    input  logic                 dbg_exit,
    input  logic                 q_overrun,
    input  logic                 evt_in,
    input  logic [1:0]           evt_cfg,
    input  logic                 lost_secure,
    input  logic                 lost_collide,
    output logic [N_LATCHED-1:0] set_vec
);
    edge_state_t st_d, st_q;

    always_comb begin
        st_d          = st_q;
        st_d.en_prev  = trace_en;
        st_d.evt_prev = evt_in;

        set_vec                = '0;
        set_vec[CAUSE_ENABLE]  = trace_en && !st_q.en_prev;
        set_vec[CAUSE_LPEXIT]  = lp_exit;
        set_vec[CAUSE_DBGEXIT] = dbg_exit;
        set_vec[CAUSE_OVERRUN] = q_overrun && trace_en;
        set_vec[CAUSE_EVENT]   = evt_in && !st_q.evt_prev && (evt_cfg == EVT_CFG_SYNC);
        set_vec[CAUSE_SECURE]  = lost_secure;
        set_vec[CAUSE_COLLIDE] = lost_collide;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assert_evt_gated_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (evt_cfg != EVT_CFG_SYNC) |-> !set_vec[CAUSE_EVENT]);

endmodule

// File: rtl/sync_cause_latch.sv
module sync_cause_latch #(
    parameter int           N       = 7,
    parameter logic [N-1:0] RST_SET = 1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] set_vec,
    input  logic         clr,
    output logic [N-1:0] pend_vec,
    output logic         pend_any
);
    logic [N-1:0] pend_d, pend_q;

    always_comb begin
        pend_d = clr ? '0 : pend_q;
        pend_d = pend_d | set_vec;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend_q <= RST_SET;
        end else begin
            pend_q <= pend_d;
        end
    end

    assign pend_vec = pend_q;
    assign pend_any = |pend_q;

    assert_set_sticks_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (|set_vec) |=> pend_any);

    assert_hold_without_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (pend_any && !clr) |=> pend_any);

endmodule

// File: rtl/trace_sync_ctrl.sv
module trace_sync_ctrl
    import trace_sync_pkg::*;
#(
    parameter int CNT_W      = 8,
    parameter int PERIOD_MAX = 255,
    parameter int INSTR_MAX  = 255
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       trace_en,
    input  logic       br_direct,
    input  logic       br_indirect,
    input  logic       seq_instr,
    input  logic       lp_exit,
    input  logic       dbg_exit,
    input  logic       q_overrun,
    input  logic       evt_in,
    input  logic [1:0] evt_cfg,
    input  logic       lost_secure,
    input  logic       lost_collide,
    output logic       msg_valid,
    output logic       msg_sync,
    output logic [1:0] msg_type
);
    localparam logic [N_LATCHED-1:0] PEND_RST = N_LATCHED'(1) << CAUSE_ENABLE;

    logic                 branch, fire, sync_now;
    logic [N_LATCHED-1:0] set_vec, pend_vec;
    logic                 pend_any;
    logic [N_CAUSES-1:0]  cause_all;
    logic [CNT_W-1:0]     period_cnt, instr_cnt;
    logic                 period_hit, instr_hit;
    msg_out_t             out_d, out_q;

    sync_cause_detect u_detect (
        .clk          (clk),
        .rst_n        (rst_n),
        .trace_en     (trace_en),
        .lp_exit      (lp_exit),
        .dbg_exit     (dbg_exit),
        .q_overrun    (q_overrun),
        .evt_in       (evt_in),
        .evt_cfg      (evt_cfg),
        .lost_secure  (lost_secure),
        .lost_collide (lost_collide),
        .set_vec      (set_vec)
    );

    sync_cause_latch #(
        .N       (N_LATCHED),
        .RST_SET (PEND_RST)
    ) u_latch (
        .clk      (clk),
        .rst_n    (rst_n),
        .set_vec  (set_vec),
        .clr      (sync_now),
        .pend_vec (pend_vec),
        .pend_any (pend_any)
    );

    sync_sat_counter #(
        .W   (CNT_W),
        .MAX (PERIOD_MAX)
    ) u_period_cnt (
        .clk    (clk),
        .rst_n  (rst_n),
        .clr    (sync_now),
        .inc    (fire && !sync_now),
        .cnt    (period_cnt),
        .at_max (period_hit)
    );

    sync_sat_counter #(
        .W   (CNT_W),
        .MAX (INSTR_MAX)
    ) u_instr_cnt (
        .clk    (clk),
        .rst_n  (rst_n),
        .clr    (branch),
        .inc    (seq_instr),
        .cnt    (instr_cnt),
        .at_max (instr_hit)
    );

    always_comb begin
        branch    = br_direct || br_indirect;
        fire      = branch && trace_en;
        cause_all = {instr_hit, period_hit, pend_vec};
        sync_now  = fire && (|cause_all);

        out_d       = '0;
        out_d.valid = fire;
        out_d.sync  = sync_now;
        if (fire) begin
            out_d.kind = msg_kind_t'({sync_now, br_indirect});
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_q <= '0;
        end else begin
            out_q <= out_d;
        end
    end

    assign msg_valid = out_q.valid;
    assign msg_sync  = out_q.sync;
    assign msg_type  = out_q.kind;

    assert_disabled_silent_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !trace_en |=> !msg_valid);

    assert_branch_emits_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (trace_en && branch) |=> msg_valid);

    assert_no_branch_no_msg_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !branch |=> (!msg_valid && !msg_sync && (msg_type == 2'b00)));

    assert_pending_forces_sync_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (fire && pend_any) |=> msg_sync);

    assert_sync_resets_period_R4: assert property (@(posedge clk) disable iff (!rst_n)
        sync_now |=> (period_cnt == '0));

    assert_branch_resets_instr_R5: assert property (@(posedge clk) disable iff (!rst_n)
        branch |=> (instr_cnt == '0));

endmodule

// File: tb/trace_sync_ctrl_tb.sv
`timescale 1ns/1ps
module trace_sync_ctrl_tb;

    logic       clk = 1'b0;
    logic       rst_n;
    logic       trace_en, br_direct, br_indirect, seq_instr;
    logic       lp_exit, dbg_exit, q_overrun, evt_in;
    logic [1:0] evt_cfg;
    logic       lost_secure, lost_collide;
    logic       msg_valid, msg_sync;
    logic [1:0] msg_type;

    int checks = 0;
    int errors = 0;
    bit done   = 0;

    // reference model state
    logic [6:0] m_pend;
    logic       m_en_prev, m_evt_prev;
    int         m_nsc, m_ic;
    logic       exp_valid, exp_sync;
    logic [1:0] exp_type;

    always #2 clk = ~clk;

    trace_sync_ctrl u_dut (
        .clk          (clk),
        .rst_n        (rst_n),
        .trace_en     (trace_en),
        .br_direct    (br_direct),
        .br_indirect  (br_indirect),
        .seq_instr    (seq_instr),
        .lp_exit      (lp_exit),
        .dbg_exit     (dbg_exit),
        .q_overrun    (q_overrun),
        .evt_in       (evt_in),
        .evt_cfg      (evt_cfg),
        .lost_secure  (lost_secure),
        .lost_collide (lost_collide),
        .msg_valid    (msg_valid),
        .msg_sync     (msg_sync),
        .msg_type     (msg_type)
    );

    function automatic logic [1:0] kind_of(input logic s, input logic ind);
        return {s, ind};
    endfunction

    task automatic model_reset();
        m_pend     = 7'b0000001;
        m_en_prev  = 1'b0;
        m_evt_prev = 1'b0;
        m_nsc      = 0;
        m_ic       = 0;
        exp_valid  = 1'b0;
        exp_sync   = 1'b0;
        exp_type   = 2'b00;
    endtask

    task automatic model_step();
        logic br, msg, s;
        logic [6:0] setv;
        br  = br_direct | br_indirect;
        msg = br & trace_en;
        s   = msg & ((m_pend != 0) || (m_nsc == 255) || (m_ic == 255));
        exp_valid = msg;
        exp_sync  = s;
        exp_type  = msg ? kind_of(s, br_indirect) : 2'b00;
        setv = {lost_collide, lost_secure,
                evt_in & ~m_evt_prev & (evt_cfg == 2'b01),
                q_overrun & trace_en, dbg_exit, lp_exit,
                trace_en & ~m_en_prev};
        m_pend = (s ? 7'b0 : m_pend) | setv;
        if (s) m_nsc = 0;
        else if (msg && m_nsc < 255) m_nsc++;
        if (br) m_ic = 0;
        else if (seq_instr && m_ic < 255) m_ic++;
        m_en_prev  = trace_en;
        m_evt_prev = evt_in;
    endtask

    task automatic clear_pulses();
        br_direct = 0; br_indirect = 0; seq_instr = 0;
        lp_exit = 0; dbg_exit = 0; q_overrun = 0;
        lost_secure = 0; lost_collide = 0;
    endtask

    // inputs are already driven (just after a falling edge); advance one cycle and compare
    task automatic tick(input string tag);
        model_step();
        @(negedge clk);
        checks++;
        if (msg_valid !== exp_valid || msg_sync !== exp_sync || msg_type !== exp_type) begin
            errors++;
            $display("FAIL %s valid/sync/type got %0b/%0b/%0d expected %0b/%0b/%0d",
                     tag, msg_valid, msg_sync, msg_type, exp_valid, exp_sync, exp_type);
        end
        clear_pulses();
    endtask

    task automatic expect_sync(input string tag, input logic want);
        checks++;
        if (exp_sync !== want) begin
            errors++;
            $display("FAIL %s model sync got %0b expected %0b", tag, exp_sync, want);
        end
    endtask

    initial begin
        #(4 * 200000);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h5eed_2024));
        rst_n = 0; trace_en = 1; evt_in = 0; evt_cfg = 2'b01;
        clear_pulses();
        model_reset();
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        model_step();  // idle cycle right after reset (enable edge seen by both)
        checks++;
        if (msg_valid !== 0 || msg_sync !== 0 || msg_type !== 0) begin
            errors++;
            $display("FAIL R10 reset outputs got %0b/%0b/%0d expected 0/0/0",
                     msg_valid, msg_sync, msg_type);
        end

        // R1: first message after reset carries sync
        br_direct = 1; tick("R1"); expect_sync("R1", 1);
        // R8: nothing pending -> compact, indirect kind
        br_indirect = 1; tick("R8"); expect_sync("R8", 0);
        // R10: both strobes -> indirect
        br_direct = 1; br_indirect = 1; tick("R10");

        // R2: low-power and debug exit
        lp_exit = 1; tick("R2");
        br_direct = 1; tick("R2"); expect_sync("R2", 1);
        br_direct = 1; tick("R2"); expect_sync("R2", 0);
        dbg_exit = 1; tick("R2");
        br_indirect = 1; tick("R2"); expect_sync("R2", 1);

        // R3: overrun while enabled
        q_overrun = 1; tick("R3");
        br_direct = 1; tick("R3"); expect_sync("R3", 1);

        // R9 and R1: disabled -> silent, re-enable -> sync
        trace_en = 0; tick("R9");
        br_direct = 1; tick("R9");
        br_indirect = 1; tick("R9");
        trace_en = 1; tick("R1");
        br_direct = 1; tick("R1"); expect_sync("R1", 1);
        br_direct = 1; tick("R1"); expect_sync("R1", 0);

        // R6: event edge ignored with another control value, accepted with 01
        evt_cfg = 2'b10; evt_in = 1; tick("R6");
        evt_in = 0; br_direct = 1; tick("R6"); expect_sync("R6", 0);
        evt_cfg = 2'b01; evt_in = 1; tick("R6");
        br_direct = 1; tick("R6"); expect_sync("R6", 1);
        br_direct = 1; tick("R6"); expect_sync("R6", 0);
        evt_in = 0; tick("R6");

        // R7: both loss kinds
        lost_secure = 1; tick("R7");
        br_indirect = 1; tick("R7"); expect_sync("R7", 1);
        lost_collide = 1; tick("R7");
        br_direct = 1; tick("R7"); expect_sync("R7", 1);

        // R8: cause in same cycle as a sync message stays pending
        dbg_exit = 1; tick("R8");
        br_direct = 1; lp_exit = 1; tick("R8"); expect_sync("R8", 1);
        br_direct = 1; tick("R8"); expect_sync("R8", 1);
        // cause in same cycle as a compact message applies to the next one
        br_direct = 1; lost_secure = 1; tick("R8"); expect_sync("R8", 0);
        br_direct = 1; tick("R8"); expect_sync("R8", 1);

        // R4: 255 compact messages then one with sync
        for (int i = 0; i < 255; i++) begin
            br_direct = 1; tick("R4");
        end
        expect_sync("R4", 0);
        br_indirect = 1; tick("R4"); expect_sync("R4", 1);
        br_direct = 1; tick("R4"); expect_sync("R4", 0);

        // R5: 254 instructions -> compact, 255 -> sync
        for (int i = 0; i < 254; i++) begin
            seq_instr = 1; tick("R5");
        end
        br_direct = 1; tick("R5"); expect_sync("R5", 0);
        for (int i = 0; i < 255; i++) begin
            seq_instr = 1; tick("R5");
        end
        br_direct = 1; tick("R5"); expect_sync("R5", 1);
        // branch coinciding with an instruction strobe clears the count
        for (int i = 0; i < 254; i++) begin
            seq_instr = 1; tick("R5");
        end
        seq_instr = 1; br_direct = 1; tick("R5"); expect_sync("R5", 0);
        br_direct = 1; tick("R5"); expect_sync("R5", 0);

        // randomised phase
        for (int i = 0; i < 4000; i++) begin
            br_direct    = ($urandom_range(99) < 20);
            br_indirect  = ($urandom_range(99) < 12);
            seq_instr    = ($urandom_range(99) < 80);
            lp_exit      = ($urandom_range(999) < 8);
            dbg_exit     = ($urandom_range(999) < 8);
            q_overrun    = ($urandom_range(999) < 8);
            lost_secure  = ($urandom_range(999) < 8);
            lost_collide = ($urandom_range(999) < 8);
            if ($urandom_range(99) < 5) evt_in = ~evt_in;
            if ($urandom_range(99) < 2) evt_cfg = 2'($urandom_range(3));
            if ($urandom_range(199) < 1) trace_en = ~trace_en;
            tick("R10");
        end

        done = 1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule